// File: doc/BRIEF.md
# Emulated UART Transmit Double Buffer

This block lets a local microprocessor take over the transmit side of a PC-compatible serial port. The host bus writes bytes into a transmit holding register. Internal logic moves each held byte into a second buffer, and the local microprocessor reads and consumes bytes from that buffer. The holding register and the second buffer together form a two-deep transmit path.

A reloadable character-delay countdown makes the host see transmitter-empty timing close to that of a real serial line. Each byte that moves into the second buffer restarts the countdown. The next byte cannot move until the countdown expires, and host transmitter-empty stays low until it does. When emulation is turned off, the countdown is ignored. The status bits then follow only how full the two registers are.

Both sides see a holding-empty bit and a transmitter-empty bit. The local side also gets a request line that can serve as an interrupt or as a DMA request.

Top module: `txe_emu_buf`

## Requirements
- R1: `host_thre` and `mpu_thre` are both 1 exactly when the holding register is empty.
- R2: A byte moves from the holding register to the second buffer only when three conditions hold together: the holding register is full, the second buffer is empty or being read in that cycle, and the delay countdown is at zero. When `emu_en` is 0, the countdown condition is treated as met.
- R3: Every transfer loads the countdown with `dly_reload`. The countdown then decreases by one per clock until it reaches zero. A reload value of 0 keeps it at zero permanently, so transfers can happen on consecutive cycles.
- R4: `rst` and `fifo_clr` both act on the next clock edge. They empty both registers, set the countdown to zero, drive `mpu_req` low, and set every empty bit. Because the countdown starts at zero, two host writes on consecutive cycles are both accepted: the first byte moves to the second buffer and the second byte stays held.
- R5: With `emu_en` at 1, `host_temt` is 1 only when the holding register is empty, the second buffer is empty, and the countdown is at zero.
- R6: With `emu_en` at 0, `host_temt` is 1 exactly when both the holding register and the second buffer are empty, whatever the countdown value.
- R7: `mpu_temt` equals the inverse of the second buffer's full state, and `mpu_req` equals that full state. Both change on the clock edge of the fill or of the `mpu_rd` read, with no added delay.
- R8: A host write to an already full holding register replaces the held byte with the new data and leaves all status bits unchanged.
- R9: When an `mpu_rd` read of the second buffer and a transfer happen in the same cycle, the read is taken first. The new byte is stored, and `mpu_req` stays 1.
- R10: `mpu_rdata` presents the byte currently in the second buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_clr | input | 1 | Synchronous transmit-path clear |
| emu_en | input | 1 | Enables character-delay emulation |
| dly_reload | input | DLY_W | Countdown reload value in clock ticks |
| host_wr | input | 1 | Host write strobe to the holding register |
| host_wdata | input | DATA_W | Host write data |
| mpu_rd | input | 1 | Local processor read strobe for the second buffer |
| mpu_rdata | output | DATA_W | Byte held in the second buffer |
| host_thre | output | 1 | Host holding-register-empty |
| host_temt | output | 1 | Host transmitter-empty |
| mpu_thre | output | 1 | Local holding-register-empty |
| mpu_temt | output | 1 | Local transmitter-empty (second buffer empty) |
| mpu_req | output | 1 | Interrupt / DMA request, high while the second buffer is full |

## Verification
The assertions assume that `rst` is held high for at least two clock edges at start-up. They also assume that `dly_reload` does not change in the same cycle as a transfer they check. The bench satisfies the first assumption by holding reset for five cycles. It satisfies the second by changing `dly_reload` only at the negative clock edge, so the value is stable at every rising edge. Reads of an empty buffer are allowed and have no effect. The random phase includes them, along with writes that overwrite a full holding register and occasional toggling of `emu_en` and `fifo_clr`.

// File: rtl/txe_emu_buf.sv
module txe_emu_buf #(
  parameter int DATA_W = 8,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_clr,
  input  logic              emu_en,
  input  logic [DLY_W-1:0]  dly_reload,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              mpu_rd,
  output logic [DATA_W-1:0] mpu_rdata,
  output logic              host_thre,
  output logic              host_temt,
  output logic              mpu_thre,
  output logic              mpu_temt,
  output logic              mpu_req
);

  logic              hold_full, buf_full;
  logic [DATA_W-1:0] hold_data, buf_data;
  logic [DLY_W-1:0]  dly_cnt;

  wire timed_out = (dly_cnt == '0);
  wire gate_ok   = timed_out | ~emu_en;
  wire buf_free  = ~buf_full | mpu_rd;
  wire xfer      = hold_full & buf_free & gate_ok;
  wire clr       = rst | fifo_clr;

  always_ff @(posedge clk) begin
    if (clr) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (host_wr) begin
      hold_full <= 1'b1;
      hold_data <= host_wdata;
    end else if (xfer) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      buf_full <= 1'b0;
      buf_data <= '0;
    end else if (xfer) begin
      buf_full <= 1'b1;
      buf_data <= hold_data;
    end else if (mpu_rd) begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clr)
      dly_cnt <= '0;
    else if (xfer)
      dly_cnt <= dly_reload;
    else if (!timed_out)
      dly_cnt <= dly_cnt - 1'b1;
  end

  assign mpu_rdata = buf_data;
  assign host_thre = ~hold_full;
  assign mpu_thre  = ~hold_full;
  assign mpu_temt  = ~buf_full;
  assign mpu_req   = buf_full;
  assign host_temt = ~hold_full & ~buf_full & (timed_out | ~emu_en);

  AST_BLOCKED_WHILE_TIMING: assert property (@(posedge clk) disable iff (rst)
    (emu_en && !timed_out && hold_full && !host_wr && !fifo_clr) |=> hold_full); // R2

  AST_RELOAD_ON_XFER: assert property (@(posedge clk) disable iff (rst)
    ($past(hold_full) && !$past(host_wr) && !hold_full && !$past(fifo_clr) && !$past(rst))
      |-> (dly_cnt == $past(dly_reload))); // R3

  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> (host_thre && host_temt && mpu_temt && !mpu_req)); // R4

  AST_TEMT_ORDER: assert property (@(posedge clk) disable iff (rst)
    host_temt |-> (host_thre && mpu_temt)); // R5

  AST_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    (host_wr && hold_full && !fifo_clr) |=> (hold_full && hold_data == $past(host_wdata))); // R8

  AST_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    (buf_full && !mpu_rd && !fifo_clr) |=> (mpu_req && $stable(mpu_rdata))); // R9

endmodule

// File: tb/txe_emu_buf_tb.sv
module txe_emu_buf_tb_top;
  localparam int DW = 8;
  localparam int CW = 16;

  logic clk = 0, rst = 1, fifo_clr = 0, emu_en = 1;
  logic [CW-1:0] dly_reload = '0;
  logic host_wr = 0, mpu_rd = 0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] mpu_rdata;
  logic host_thre, host_temt, mpu_thre, mpu_temt, mpu_req;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  txe_emu_buf #(.DATA_W(DW), .DLY_W(CW)) dut_i (
    .clk(clk), .rst(rst), .fifo_clr(fifo_clr), .emu_en(emu_en),
    .dly_reload(dly_reload), .host_wr(host_wr), .host_wdata(host_wdata),
    .mpu_rd(mpu_rd), .mpu_rdata(mpu_rdata), .host_thre(host_thre),
    .host_temt(host_temt), .mpu_thre(mpu_thre), .mpu_temt(mpu_temt),
    .mpu_req(mpu_req));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  int m_hf = 0, m_bf = 0, m_hd = 0, m_bd = 0, m_cnt = 0;

  always @(posedge clk) begin
    int tout, x;
    if (rst || fifo_clr) begin
      m_hf = 0; m_bf = 0; m_hd = 0; m_bd = 0; m_cnt = 0;
    end else begin
      tout = (m_cnt == 0) || !emu_en;
      x = m_hf && (!m_bf || mpu_rd) && tout;
      if (mpu_rd) m_bf = 0;
      if (x) begin
        m_bf = 1; m_bd = m_hd; m_hf = 0; m_cnt = int'(dly_reload);
      end else if (m_cnt > 0) m_cnt--;
      if (host_wr) begin m_hf = 1; m_hd = int'(host_wdata); end
    end
    #2;
    if (!rst && !done) begin
      chk("R1 host_thre", int'(host_thre), int'(!m_hf));
      chk("R1 mpu_thre", int'(mpu_thre), int'(!m_hf));
      if (emu_en) chk("R5 host_temt", int'(host_temt), int'(!m_hf && !m_bf && m_cnt == 0));
      else        chk("R6 host_temt", int'(host_temt), int'(!m_hf && !m_bf));
      chk("R7 mpu_temt", int'(mpu_temt), int'(!m_bf));
      chk("R7 mpu_req", int'(mpu_req), m_bf);
      if (m_bf) chk("R10 mpu_rdata", int'(mpu_rdata), m_bd);
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc_cnt);
      finish_run();
    end
  end

  task automatic cyc(input bit wr, input int d, input bit rd);
    host_wr = wr; host_wdata = DW'(d); mpu_rd = rd;
    @(negedge clk);
    host_wr = 0; mpu_rd = 0; fifo_clr = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    emu_en = 1; dly_reload = 4;
    chk("R4 reset thre", int'(host_thre), 1);
    chk("R4 reset temt", int'(host_temt), 1);
    chk("R4 reset req", int'(mpu_req), 0);

    cyc(1, 'h11, 0);
    cyc(1, 'h22, 0);
    chk("R4 dual write rdata", int'(mpu_rdata), 'h11);
    chk("R4 dual write held", int'(host_thre), 0);
    cyc(0, 0, 1);
    chk("R2 gated mpu_temt", int'(mpu_temt), 1);
    chk("R2 gated held", int'(host_thre), 0);
    repeat (3) cyc(0, 0, 0);
    chk("R3 not yet", int'(mpu_req), 0);
    cyc(0, 0, 0);
    chk("R3 expiry req", int'(mpu_req), 1);
    chk("R3 expiry rdata", int'(mpu_rdata), 'h22);

    cyc(1, 'h33, 0);
    repeat (3) cyc(0, 0, 0);
    cyc(0, 0, 1);
    chk("R9 req kept", int'(mpu_req), 1);
    chk("R9 rdata", int'(mpu_rdata), 'h33);
    chk("R9 hold empty", int'(host_thre), 1);

    cyc(0, 0, 1);
    cyc(1, 'h44, 0);
    cyc(1, 'h55, 0);
    chk("R8 still full", int'(host_thre), 0);
    repeat (4) cyc(0, 0, 0);
    chk("R8 latest byte", int'(mpu_rdata), 'h55);
    cyc(0, 0, 1);
    chk("R5 timer blocks temt", int'(host_temt), 0);
    chk("R7 read sets temt", int'(mpu_temt), 1);
    cyc(0, 0, 0);
    chk("R5 temt after expiry", int'(host_temt), 1);

    emu_en = 0;
    cyc(1, 'h66, 0);
    cyc(0, 0, 0);
    cyc(0, 0, 1);
    chk("R6 temt ignores timer", int'(host_temt), 1);

    emu_en = 1; dly_reload = 0;
    repeat (6) cyc(0, 0, 0);
    cyc(1, 'h77, 0);
    cyc(0, 0, 0);
    cyc(1, 'h88, 1);
    cyc(0, 0, 0);
    chk("R3 zero reload req", int'(mpu_req), 1);
    chk("R3 zero reload rdata", int'(mpu_rdata), 'h88);

    cyc(1, 'h99, 0);
    fifo_clr = 1;
    cyc(0, 0, 0);
    chk("R4 clear req", int'(mpu_req), 0);
    chk("R4 clear temt", int'(host_temt), 1);
    chk("R4 clear thre", int'(host_thre), 1);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 199) == 0) emu_en = ~emu_en;
      if ($urandom_range(0, 99) == 0) dly_reload = CW'($urandom_range(0, 6));
      if ($urandom_range(0, 149) == 0) fifo_clr = 1;
      cyc($urandom_range(0, 3) == 0, int'($urandom_range(0, 255)), $urandom_range(0, 2) == 0);
    end
    finish_run();
  end
endmodule